// File: doc/BRIEF.md
# Queued SPI Master Sequencer

This block is an SPI master that works through a small circular queue of transmit and receive entries without help from the host. The host loads transmit bytes into the queue, sets a start and an end index, picks an SCK divider and sets the enable bit. The sequencer then shifts one 8-bit frame per entry. It stores each received byte at the index of the entry that sent it. At the end index it either finishes, or it loops back to the start index when wraparound is enabled.

A looping queue can be stopped in three ways. Clearing wraparound lets the current lap run out to the end index, and the block then finishes. A halt request lets the frame in progress complete and then parks the sequencer. Clearing enable stops the block at once and throws away a partly shifted frame. The bidirectional slave-select pin is a guard. When it is configured as an input and another device pulls it low while this block is master, the block records a mode fault, drops its enable bit and gives the serial pins back to general-purpose port values.

The host side is a single-cycle register port with no back-pressure. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. A read has a side effect only when `reg_rd` is high. No data stream crosses the block edge with a handshake, so every pin is plain control or status.

Top module: `spi_queue_master`

## Requirements
- R1: Register map (5-bit address). Bit 4 set selects the queue: writes go to transmit entry `addr[3:0]` and reads return receive entry `addr[3:0]`. Otherwise `addr[2:0]` selects a register: 0 control, 1 range (start index in [3:0], end index in [7:4]), 2 divider N, 3 status, 4 port values. Control bits: [0] enable, [1] wrap, [2] halt, [3] slave-select direction (1 = general-purpose output), [4] finish interrupt enable, [5] fault interrupt enable, [6] master. Status bits: [0] finished, [1] mode fault, [2] halted, [3] busy. Port value bits: [0] SCK, [1] MOSI, [2] chip select, [3] slave-select output. Reset clears all registers except the port values, which reset to 4'b1100. Reset also clears every queue entry.
- R2: On a rising edge of enable (with master set), the current index loads the start index. The sequencer then shifts entries in increasing index order, wrapping from 15 to 0, up to and including the end index. Each receive entry is written with the byte received while its own transmit entry was shifted. After the end entry it sets finished, clears enable and stops.
- R3: A frame is 8 bits, MSB first, with SCK idle low. MOSI changes on falling edges and MISO is sampled on rising edges. Each SCK level lasts N clocks (N = 0 acts as 1), so chip select is low for exactly 16*max(N,1) clocks per frame.
- R4: With wrap set, the sequencer returns to the start index after the end entry and never finishes. After wrap is cleared, it finishes on the next end entry.
- R5: With halt set, the frame in progress completes and is stored. The sequencer then parks with status halted set and chip select high. Clearing halt resumes at the next index.
- R6: Clearing enable abandons the frame in progress at once. SCK stops and the partial frame is not stored.
- R7: While enable is clear, SCK, MOSI and chip select show the port-value bits. The slave-select pin always drives port-value bit 3, and its output enable is the direction bit.
- R8: If master is set, the direction bit is 0 and `ss_i` is low at a clock edge, the mode-fault flag sets and enable clears on that edge.
- R9: With the direction bit at 1, a low `ss_i` never sets the mode-fault flag.
- R10: A status flag clears only on a status write with 0 in its bit that follows a status read which saw that flag set. Writing 1, or writing 0 without that read, leaves the flag set.
- R11: `irq` is high exactly while (finished and finish interrupt enable) or (mode fault and fault interrupt enable).
- R12: After a fault or a finish, setting enable again restarts the queue from the start index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 5 | Register or queue address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |
| ss_i | input | 1 | Slave-select pin input |
| ss_o | output | 1 | Slave-select pin output value |
| ss_oe | output | 1 | Slave-select pin output enable |

## Verification
A wrong current index shows up at the receive entries after the next finish. An entry outside the start-to-end window becomes non-zero, or an entry inside it keeps its reset value, so the error is visible within one pass of the queue. A stuck shifter phase shows up in the very next frame, because chip select stays low for a time other than 16*N clocks or the captured MOSI byte differs from the entry. A wrong enable or fault state shows up on the next clock edge: the serial pins fail to switch to the port values and `irq` disagrees with the flags.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_RANGE = 3'd1;
  localparam logic [2:0] A_DIV   = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_PORT  = 3'd4;

  localparam logic [3:0] PORT_RST = 4'b1100;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_SHIFT,
    SQ_HALT
  } sq_state_t;
endpackage

// File: rtl/spiq_shift.sv
module spiq_shift #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DIV_W-1:0] div,
  input  logic [DW-1:0]    txd,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rxd
);
  localparam int BW = $clog2(DW);

  logic [DW-1:0]    sreg;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic [BW-1:0]    bcnt;
  logic             rbit;
  logic             last;

  assign half = (div == '0) ? DIV_W'(1) : div;
  assign last = (cnt == half - DIV_W'(1));
  assign mosi = sreg[DW-1];
  assign rxd  = sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
      bcnt <= '0;
      rbit <= 1'b0;
      sck  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        sck  <= 1'b0;
        cnt  <= '0;
      end else if (start) begin
        busy <= 1'b1;
        sreg <= txd;
        sck  <= 1'b0;
        cnt  <= '0;
        bcnt <= '0;
      end else if (busy) begin
        if (!last) begin
          cnt <= cnt + DIV_W'(1);
        end else begin
          cnt <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            rbit <= miso;
          end else begin
            sck  <= 1'b0;
            sreg <= {sreg[DW-2:0], rbit};
            if (bcnt == BW'(DW - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bcnt <= bcnt + BW'(1);
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spiq_seq.sv
module spiq_seq
  import spiq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             en_rise,
  input  logic             wrap,
  input  logic             halt,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [IDX_W-1:0] end_idx,
  input  logic             sh_done,
  output logic             sh_start,
  output logic             rx_we,
  output logic [IDX_W-1:0] idx,
  output logic             fin_pulse,
  output logic             halted,
  output logic             busy
);
  sq_state_t st;
  logic      at_end;

  assign at_end    = (idx == end_idx);
  assign sh_start  = en && (st == SQ_LOAD);
  assign rx_we     = en && (st == SQ_SHIFT) && sh_done;
  assign fin_pulse = rx_we && at_end && !wrap;
  assign halted    = (st == SQ_HALT);
  assign busy      = (st != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      idx <= '0;
    end else if (!en) begin
      st <= SQ_IDLE;
    end else begin
      case (st)
        SQ_IDLE: if (en_rise) begin
          idx <= start_idx;
          st  <= SQ_LOAD;
        end
        SQ_LOAD: st <= SQ_SHIFT;
        SQ_SHIFT: if (sh_done) begin
          if (fin_pulse) begin
            st <= SQ_IDLE;
          end else begin
            idx <= at_end ? start_idx : idx + IDX_W'(1);
            st  <= halt ? SQ_HALT : SQ_LOAD;
          end
        end
        SQ_HALT: if (!halt) st <= SQ_LOAD;
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import spiq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DIV_W  = 8,
  parameter int QDEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [$clog2(QDEPTH):0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe
);
  localparam int IDX_W = $clog2(QDEPTH);

  logic             en_r, wrap_r, halt_r, ssout_r, finie_r, mfie_r, mstr_r;
  logic [IDX_W-1:0] start_r, end_r;
  logic [DIV_W-1:0] div_r;
  logic [3:0]       port_r;
  logic             fin_r, mf_r, seen_fin, seen_mf, run_d;
  logic [DW-1:0]    txq [QDEPTH];
  logic [DW-1:0]    rxq [QDEPTH];

  logic             sel_q, stat_wr, stat_rd, fault_cond, run, run_rise;
  logic [IDX_W-1:0] qidx, idx;
  logic             sh_start, sh_done, sh_busy, sh_sck, sh_mosi;
  logic [DW-1:0]    sh_rxd;
  logic             rx_we, fin_pulse, halted, seq_busy;

  assign sel_q      = reg_addr[IDX_W];
  assign qidx       = reg_addr[IDX_W-1:0];
  assign stat_wr    = reg_wr && !sel_q && (reg_addr[2:0] == A_STAT);
  assign stat_rd    = reg_rd && !sel_q && (reg_addr[2:0] == A_STAT);
  assign fault_cond = mstr_r && !ssout_r && !ss_i;
  assign run        = en_r && mstr_r;
  assign run_rise   = run && !run_d;

  spiq_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(run), .en_rise(run_rise),
    .wrap(wrap_r), .halt(halt_r), .start_idx(start_r), .end_idx(end_r),
    .sh_done(sh_done), .sh_start(sh_start), .rx_we(rx_we), .idx(idx),
    .fin_pulse(fin_pulse), .halted(halted), .busy(seq_busy)
  );

  spiq_shift #(.DW(DW), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .abort(!run),
    .div(div_r), .txd(txq[idx]), .miso(miso_i), .sck(sh_sck),
    .mosi(sh_mosi), .busy(sh_busy), .done(sh_done), .rxd(sh_rxd)
  );

  // Control, range, divider and port registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {mstr_r, mfie_r, finie_r, ssout_r, halt_r, wrap_r, en_r} <= '0;
      start_r <= '0;
      end_r   <= '0;
      div_r   <= '0;
      port_r  <= PORT_RST;
      run_d   <= 1'b0;
    end else begin
      run_d <= run;
      if (reg_wr && !sel_q) begin
        case (reg_addr[2:0])
          A_CTRL:  {mstr_r, mfie_r, finie_r, ssout_r, halt_r, wrap_r, en_r} <= reg_wdata[6:0];
          A_RANGE: begin
            start_r <= reg_wdata[IDX_W-1:0];
            end_r   <= reg_wdata[2*IDX_W-1:IDX_W];
          end
          A_DIV:   div_r  <= reg_wdata[DIV_W-1:0];
          A_PORT:  port_r <= reg_wdata[3:0];
          default: ;
        endcase
      end
      if (fin_pulse || fault_cond) en_r <= 1'b0;
    end
  end

  // Sticky flags with read-then-write-zero clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_r    <= 1'b0;
      mf_r     <= 1'b0;
      seen_fin <= 1'b0;
      seen_mf  <= 1'b0;
    end else begin
      if (stat_rd && fin_r) seen_fin <= 1'b1;
      if (stat_rd && mf_r)  seen_mf  <= 1'b1;
      if (stat_wr && seen_fin && !reg_wdata[0]) begin
        fin_r    <= 1'b0;
        seen_fin <= 1'b0;
      end
      if (stat_wr && seen_mf && !reg_wdata[1]) begin
        mf_r    <= 1'b0;
        seen_mf <= 1'b0;
      end
      if (fin_pulse)  fin_r <= 1'b1;
      if (fault_cond) mf_r  <= 1'b1;
    end
  end

  // Queue storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < QDEPTH; i++) begin
        txq[i] <= '0;
        rxq[i] <= '0;
      end
    end else begin
      if (reg_wr && sel_q) txq[qidx] <= reg_wdata;
      if (rx_we)           rxq[idx]  <= sh_rxd;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_q) begin
      reg_rdata = rxq[qidx];
    end else begin
      case (reg_addr[2:0])
        A_CTRL:  reg_rdata = DW'({mstr_r, mfie_r, finie_r, ssout_r, halt_r, wrap_r, en_r});
        A_RANGE: reg_rdata = DW'({end_r, start_r});
        A_DIV:   reg_rdata = DW'(div_r);
        A_STAT:  reg_rdata = DW'({seq_busy, halted, mf_r, fin_r});
        A_PORT:  reg_rdata = DW'(port_r);
        default: reg_rdata = '0;
      endcase
    end
  end

  assign irq    = (fin_r && finie_r) || (mf_r && mfie_r);
  assign sck_o  = run ? sh_sck   : port_r[0];
  assign mosi_o = run ? sh_mosi  : port_r[1];
  assign cs_n_o = run ? !sh_busy : port_r[2];
  assign ss_o   = port_r[3];
  assign ss_oe  = ssout_r;
endmodule

// File: rtl/spiq_chk.sv
module spiq_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic fin,
  input logic mf,
  input logic finie,
  input logic mfie,
  input logic mstr,
  input logic ss_i,
  input logic ss_oe,
  input logic sh_busy,
  input logic halted,
  input logic stat_wr,
  input logic irq
);
  AST_FAULT_NEEDS_LOW_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf) |-> $past(mstr && !ss_oe && !ss_i)); // R9
  AST_FAULT_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf) |-> !en); // R8
  AST_FINISH_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> !en); // R2
  AST_ABORT_STOPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sh_busy); // R6
  AST_HALT_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !sh_busy); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mf && !stat_wr) |=> mf); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!finie && !mfie) |-> !irq); // R11
endmodule

bind spi_queue_master spiq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_r), .fin(fin_r), .mf(mf_r),
  .finie(finie_r), .mfie(mfie_r), .mstr(mstr_r), .ss_i(ss_i),
  .ss_oe(ss_oe), .sh_busy(sh_busy), .halted(halted),
  .stat_wr(stat_wr), .irq(irq)
);

// File: tb/spi_queue_master_bench.sv
`timescale 1ns/1ps
module spi_queue_master_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, sck_o, mosi_o, cs_n_o, ss_o, ss_oe;
  logic       ss_i = 1'b1;
  logic       miso_i;

  int checks = 0, fails = 0, cycles = 0, lowcnt = 0;
  logic [7:0] capreg = '0;
  logic [7:0] txv [16];

  spi_queue_master u_spi_queue_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .cs_n_o(cs_n_o), .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
  );

  assign miso_i = ~mosi_o;   // inverted loopback: each entry receives ~tx
  always #2 clk = ~clk;
  always @(posedge sck_o) capreg <= {capreg[6:0], mosi_o};
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !cs_n_o) lowcnt++;
    if (cycles == 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  function automatic logic [7:0] cv(input bit en, wrap, halt, sso, fie, mie, ms);
    return {1'b0, ms, mie, fie, sso, halt, wrap, en};
  endfunction

  task automatic load_tx(input int seed);
    for (int i = 0; i < 16; i++) begin
      txv[i] = 8'((i * 37 + seed * 11) ^ 8'h5A);
      wr(5'(16 + i), txv[i]);
    end
  endtask

  task automatic wait_fin(input string tag);
    logic [7:0] s;
    s = '0;
    for (int k = 0; k < 3000 && !s[0]; k++) rd(5'd3, s);
    check(tag, int'(s[0]), 1);
  endtask

  logic [7:0] d;
  int expv, seed;

  initial begin
    do_reset();
    // reset state
    rd(5'd0, d); check("R1 ctrl reset", d, 0);
    rd(5'd3, d); check("R1 status reset", d, 0);
    rd(5'd4, d); check("R1 port reset", d, 8'h0C);
    check("R7 idle pins", {sck_o, mosi_o, cs_n_o, ss_o, ss_oe}, 5'b00110);
    check("R11 irq reset", irq, 0);

    // R2: sweep start/end windows including wrap through index 0
    seed = 0;
    foreach (txv[i]) txv[i] = '0;
    for (int s = 0; s < 16; s += 5) begin
      for (int e = 0; e < 16; e++) begin
        do_reset();
        seed++;
        load_tx(seed);
        wr(5'd1, 8'((e << 4) | s));
        wr(5'd2, 8'd1);
        wr(5'd0, cv(1, 0, 0, 1, 0, 0, 1));
        wait_fin("R2 finish");
        rd(5'd0, d); check("R2 enable cleared", d[0], 0);
        for (int i = 0; i < 16; i++) begin
          rd(5'(16 + i), d);
          expv = (((i - s) & 15) <= ((e - s) & 15)) ? int'(8'(~txv[i])) : 0;
          check("R2 rx entry", d, expv);
        end
      end
    end

    // R3: frame format and SCK divider
    for (int n = 0; n < 6; n++) begin
      do_reset();
      wr(5'd19, 8'(8'hA5 ^ n));
      wr(5'd1, 8'h33);
      wr(5'd2, 8'(n));
      lowcnt = 0;
      wr(5'd0, cv(1, 0, 0, 1, 0, 0, 1));
      wait_fin("R3 finish");
      check("R3 cs low cycles", lowcnt, 16 * ((n == 0) ? 1 : n));
      check("R3 mosi bits", capreg, 8'(8'hA5 ^ n));
      rd(5'd19, d); check("R3 rx bits", d, 8'(~(8'hA5 ^ n)));
    end

    // R4: wrap loops, then clearing wrap finishes on the end entry
    do_reset();
    load_tx(77);
    wr(5'd1, 8'h42);
    wr(5'd2, 8'd1);
    wr(5'd0, cv(1, 1, 0, 1, 0, 0, 1));
    tick(400);
    rd(5'd3, d);
    check("R4 looping not finished", d[0], 0);
    check("R4 looping busy", d[3], 1);
    wr(5'd0, cv(1, 0, 0, 1, 0, 0, 1));
    wait_fin("R4 finish after wrap off");
    check("R4 last frame is end entry", capreg, txv[4]);
    rd(5'd0, d); check("R4 enable cleared", d[0], 0);
    rd(5'd17, d); check("R4 outside window", d, 0);

    // R5: halt after current frame, resume at next index
    do_reset();
    load_tx(5);
    wr(5'd1, 8'h70);
    wr(5'd2, 8'd2);
    wr(5'd0, cv(1, 0, 0, 1, 0, 0, 1));
    tick(40);
    wr(5'd0, cv(1, 0, 1, 1, 0, 0, 1));
    tick(100);
    rd(5'd3, d); check("R5 halted bit", d[2], 1);
    check("R5 cs high while halted", cs_n_o, 1);
    rd(5'd17, d); check("R5 frame completed", d, 8'(~txv[1]));
    rd(5'd18, d); check("R5 next not started", d, 0);
    wr(5'd0, cv(1, 0, 0, 1, 0, 0, 1));
    wait_fin("R5 finish after resume");
    rd(5'd18, d); check("R5 resumed entry", d, 8'(~txv[2]));
    rd(5'd23, d); check("R5 end entry", d, 8'(~txv[7]));

    // R6/R7: immediate abort and pin handover
    do_reset();
    load_tx(9);
    wr(5'd4, 8'h0D);
    wr(5'd1, 8'h30);
    wr(5'd2, 8'd4);
    wr(5'd0, cv(1, 0, 0, 1, 0, 0, 1));
    tick(20);
    check("R6 frame active", cs_n_o, 0);
    wr(5'd0, cv(0, 0, 0, 1, 0, 0, 1));
    check("R7 pins to port values", {sck_o, mosi_o, cs_n_o, ss_o}, 4'b1011);
    tick(100);
    rd(5'd3, d); check("R6 stopped", d, 0);
    rd(5'd16, d); check("R6 partial not stored", d, 0);

    // R8/R10/R11/R12: mode fault
    do_reset();
    load_tx(21);
    wr(5'd4, 8'h0B);
    wr(5'd1, 8'h70);
    wr(5'd2, 8'd4);
    wr(5'd0, cv(1, 0, 0, 0, 0, 1, 1));
    check("R7 ss output enable off", ss_oe, 0);
    tick(100);
    ss_i = 1'b0;
    tick(2);
    check("R11 fault irq", irq, 1);
    check("R8 pins to port values", {sck_o, mosi_o, cs_n_o}, 3'b110);
    rd(5'd0, d); check("R8 enable cleared", d[0], 0);
    ss_i = 1'b1;
    wr(5'd3, 8'h00);
    rd(5'd3, d); check("R10 write without read keeps flag", d[1], 1);
    wr(5'd3, 8'h02);
    rd(5'd3, d); check("R10 write one keeps flag", d[1], 1);
    wr(5'd3, 8'h00);
    rd(5'd3, d); check("R10 read then zero clears", d[1], 0);
    check("R11 irq after clear", irq, 0);
    rd(5'd16, d); check("R12 first frame before fault", d, 8'(~txv[0]));
    txv[0] = 8'h3C;
    wr(5'd16, txv[0]);
    wr(5'd0, cv(1, 0, 0, 0, 0, 1, 1));
    wait_fin("R12 restart finish");
    rd(5'd16, d); check("R12 restart from start index", d, 8'hC3);
    rd(5'd23, d); check("R12 end entry", d, 8'(~txv[7]));
    check("R11 finish masked", irq, 0);
    wr(5'd0, cv(0, 0, 0, 0, 1, 1, 1));
    tick(1);
    check("R11 finish irq", irq, 1);
    rd(5'd3, d);
    wr(5'd3, 8'h00);
    tick(1);
    check("R11 finish irq cleared", irq, 0);

    // R9: direction output disables fault checking
    do_reset();
    load_tx(3);
    wr(5'd1, 8'h20);
    wr(5'd2, 8'd1);
    ss_i = 1'b0;
    wr(5'd0, cv(1, 0, 0, 1, 0, 1, 1));
    wait_fin("R9 finish with ss low");
    rd(5'd3, d); check("R9 no fault", d[1], 0);
    check("R9 irq quiet", irq, 0);
    rd(5'd18, d); check("R9 entry stored", d, 8'(~txv[2]));
    ss_i = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule